// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block chooses where each source operand of a five-stage pipeline comes from. For the two operands that the execute stage is about to consume, it compares the source register indices with the destinations of the two older instructions still in flight. It then routes one of three values to the execute-stage input: the operand already latched in the decode/execute register, the ALU result held in the execute/memory register, or the final write-back value. The younger producer wins when both older instructions target the same register.

The decode stage gets a second, simpler path. When a decode source index names the register that write-back is updating in the same cycle, the write-back value is passed through in place of the stale register-file read. A loaded value only exists once the memory stage has finished, so forwarding cannot feed an instruction that consumes a load result in the very next slot. The unit flags that case with a stall request, and the surrounding pipeline inserts a one-cycle bubble. Register zero is hard-wired and is never a forwarding target. The block is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory stage writes a nonzero register equal to an execute source index, that operand's select is 2'b01 and its output equals the execute/memory ALU result.
- R2: When only the write-back stage writes a nonzero register equal to an execute source index, that operand's select is 2'b10 and its output equals the write-back data.
- R3: When both the execute/memory and write-back stages write the register named by an execute source, select 2'b01 (the newer producer) is chosen.
- R4: With no enabled matching writer, the select is 2'b00 and the output equals that operand's decode/execute register value.
- R5: A source index of 0 always gets select 2'b00, even if a stage claims to write register 0.
- R6: The two operands are resolved independently; a match on one never changes the other's select or output.
- R7: A decode output equals the write-back data when write-back is enabled, its destination is nonzero, and it equals that decode source index; otherwise it equals the register-file read data.
- R8: The stall request is high exactly when the execute instruction is a load, its destination is nonzero, and that destination equals either decode source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_idx_i | input | NUM_SRC x IDX_W | Execute-stage source register indices |
| ex_src_val_i | input | NUM_SRC x DATA_W | Operand values from the decode/execute register |
| exm_rd_i | input | IDX_W | Execute/memory destination index |
| exm_we_i | input | 1 | Execute/memory register write enable |
| exm_alu_i | input | DATA_W | Execute/memory ALU result |
| mwb_rd_i | input | IDX_W | Memory/write-back destination index |
| mwb_we_i | input | 1 | Memory/write-back register write enable |
| mwb_data_i | input | DATA_W | Final write-back value (ALU or load data) |
| id_src_idx_i | input | NUM_SRC x IDX_W | Decode-stage source register indices |
| rf_rdata_i | input | NUM_SRC x DATA_W | Register-file read data for decode sources |
| ex_is_load_i | input | 1 | Execute-stage instruction is a load |
| ex_rd_i | input | IDX_W | Execute-stage destination index |
| ex_sel_o | output | NUM_SRC x 2 | Per-operand source select (00 reg, 01 exec/mem, 10 write-back) |
| ex_opnd_o | output | NUM_SRC x DATA_W | Forwarded execute-stage operands |
| id_opnd_o | output | NUM_SRC x DATA_W | Decode operands after write-through bypass |
| load_stall_o | output | 1 | One-cycle load-use stall request |

## Verification
The bench targets the case where two in-flight instructions write the same register. A unit with the wrong priority would hand the older write-back value to the execute stage and silently compute with stale data. It drives writes to register 0 with the enables high, where a unit lacking the zero guard would replace a constant zero with garbage. It also checks matches with the write enable low, which a unit comparing indices alone would wrongly forward. Load-use is exercised on each decode source, with a zero destination and with a non-load producer, so that a missing or over-eager stall shows up as a wrong stall bit.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_REG = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_src_sel.sv
module fwd_src_sel
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [IDX_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [IDX_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);
  logic src_live;
  logic mem_hit;
  logic wb_hit;

  assign src_live = (src_idx_i != '0);
  assign mem_hit  = mem_we_i && (mem_rd_i == src_idx_i);
  assign wb_hit   = wb_we_i && (wb_rd_i == src_idx_i);

  // newer producer first
  always_comb begin
    sel_o = SEL_REG;
    if (src_live) begin
      if (mem_hit)     sel_o = SEL_MEM;
      else if (wb_hit) sel_o = SEL_WB;
    end
  end
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel_i,
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [DATA_W-1:0] mem_val_i,
  input  logic [DATA_W-1:0] wb_val_i,
  output logic [DATA_W-1:0] opnd_o
);
  always_comb begin
    unique case (sel_i)
      SEL_MEM: opnd_o = mem_val_i;
      SEL_WB:  opnd_o = wb_val_i;
      default: opnd_o = reg_val_i;
    endcase
  end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  src_idx_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  input  logic [IDX_W-1:0]  wb_rd_i,
  input  logic              wb_we_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic [DATA_W-1:0] opnd_o
);
  logic hit;

  assign hit    = wb_we_i && (src_idx_i != '0) && (src_idx_i == wb_rd_i);
  assign opnd_o = hit ? wb_data_i : rf_rdata_i;
endmodule

// File: rtl/load_use_det.sv
module load_use_det #(
  parameter int NUM_SRC = 2,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0][IDX_W-1:0] id_src_idx_i,
  input  logic                          ex_is_load_i,
  input  logic [IDX_W-1:0]              ex_rd_i,
  output logic                          stall_o
);
  logic [NUM_SRC-1:0] src_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign src_hit[g] = (id_src_idx_i[g] == ex_rd_i);
  end

  assign stall_o = ex_is_load_i && (ex_rd_i != '0) && (|src_hit);
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_SRC-1:0][IDX_W-1:0]  ex_src_idx_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] ex_src_val_i,
  input  logic [IDX_W-1:0]               exm_rd_i,
  input  logic                           exm_we_i,
  input  logic [DATA_W-1:0]              exm_alu_i,
  input  logic [IDX_W-1:0]               mwb_rd_i,
  input  logic                           mwb_we_i,
  input  logic [DATA_W-1:0]              mwb_data_i,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]  id_src_idx_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] rf_rdata_i,
  input  logic                           ex_is_load_i,
  input  logic [IDX_W-1:0]               ex_rd_i,
  output logic [NUM_SRC-1:0][1:0]        ex_sel_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0] ex_opnd_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0] id_opnd_o,
  output logic                           load_stall_o
);
  fwd_sel_e sel [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    fwd_src_sel #(.IDX_W(IDX_W)) u_sel (
      .src_idx_i (ex_src_idx_i[g]),
      .mem_rd_i  (exm_rd_i),
      .mem_we_i  (exm_we_i),
      .wb_rd_i   (mwb_rd_i),
      .wb_we_i   (mwb_we_i),
      .sel_o     (sel[g])
    );

    fwd_opnd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i     (sel[g]),
      .reg_val_i (ex_src_val_i[g]),
      .mem_val_i (exm_alu_i),
      .wb_val_i  (mwb_data_i),
      .opnd_o    (ex_opnd_o[g])
    );

    rf_bypass #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_byp (
      .src_idx_i  (id_src_idx_i[g]),
      .rf_rdata_i (rf_rdata_i[g]),
      .wb_rd_i    (mwb_rd_i),
      .wb_we_i    (mwb_we_i),
      .wb_data_i  (mwb_data_i),
      .opnd_o     (id_opnd_o[g])
    );

    assign ex_sel_o[g] = sel[g];
  end

  load_use_det #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_lud (
    .id_src_idx_i (id_src_idx_i),
    .ex_is_load_i (ex_is_load_i),
    .ex_rd_i      (ex_rd_i),
    .stall_o      (load_stall_o)
  );
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int NUM_SRC = 2,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32
) (
  input logic [NUM_SRC-1:0][IDX_W-1:0]  ex_src_idx_i,
  input logic [NUM_SRC-1:0][DATA_W-1:0] ex_src_val_i,
  input logic [IDX_W-1:0]               exm_rd_i,
  input logic                           exm_we_i,
  input logic [DATA_W-1:0]              exm_alu_i,
  input logic [IDX_W-1:0]               mwb_rd_i,
  input logic                           mwb_we_i,
  input logic [DATA_W-1:0]              mwb_data_i,
  input logic [NUM_SRC-1:0][IDX_W-1:0]  id_src_idx_i,
  input logic [NUM_SRC-1:0][DATA_W-1:0] rf_rdata_i,
  input logic                           ex_is_load_i,
  input logic [IDX_W-1:0]               ex_rd_i,
  input logic [NUM_SRC-1:0][1:0]        ex_sel_o,
  input logic [NUM_SRC-1:0][DATA_W-1:0] ex_opnd_o,
  input logic [NUM_SRC-1:0][DATA_W-1:0] id_opnd_o,
  input logic                           load_stall_o
);
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      AST_SEL_NOT_11: assert (ex_sel_o[i] != 2'b11); // R4
      AST_ZERO_NO_FWD: assert (ex_src_idx_i[i] != '0 || ex_sel_o[i] == 2'b00); // R5
      AST_MEM_WINS: assert (!(exm_we_i && ex_src_idx_i[i] != '0 && exm_rd_i == ex_src_idx_i[i])
                            || ex_sel_o[i] == 2'b01); // R3
      AST_MEM_DATA: assert (ex_sel_o[i] != 2'b01 || ex_opnd_o[i] == exm_alu_i); // R1
      AST_WB_DATA: assert (ex_sel_o[i] != 2'b10 || ex_opnd_o[i] == mwb_data_i); // R2
      AST_REG_DATA: assert (ex_sel_o[i] != 2'b00 || ex_opnd_o[i] == ex_src_val_i[i]); // R4
      AST_ID_BYPASS: assert (!(mwb_we_i && id_src_idx_i[i] != '0 && id_src_idx_i[i] == mwb_rd_i)
                             || id_opnd_o[i] == mwb_data_i); // R7
      AST_ID_PASS: assert ((mwb_we_i && id_src_idx_i[i] == mwb_rd_i)
                           || id_opnd_o[i] == rf_rdata_i[i]); // R7
    end
    AST_STALL_LOAD: assert (!load_stall_o || (ex_is_load_i && ex_rd_i != '0)); // R8
  end
endmodule

bind fwd_unit fwd_unit_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
  localparam int N  = 2;
  localparam int IW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0][IW-1:0] ex_src_idx, id_src_idx;
  logic [N-1:0][DW-1:0] ex_src_val, rf_rdata;
  logic [IW-1:0] exm_rd, mwb_rd, ex_rd;
  logic exm_we, mwb_we, ex_is_load;
  logic [DW-1:0] exm_alu, mwb_data;
  logic [N-1:0][1:0] ex_sel;
  logic [N-1:0][DW-1:0] ex_opnd, id_opnd;
  logic load_stall;

  fwd_unit #(.NUM_SRC(N), .IDX_W(IW), .DATA_W(DW)) u0 (
    .ex_src_idx_i(ex_src_idx), .ex_src_val_i(ex_src_val),
    .exm_rd_i(exm_rd), .exm_we_i(exm_we), .exm_alu_i(exm_alu),
    .mwb_rd_i(mwb_rd), .mwb_we_i(mwb_we), .mwb_data_i(mwb_data),
    .id_src_idx_i(id_src_idx), .rf_rdata_i(rf_rdata),
    .ex_is_load_i(ex_is_load), .ex_rd_i(ex_rd),
    .ex_sel_o(ex_sel), .ex_opnd_o(ex_opnd), .id_opnd_o(id_opnd),
    .load_stall_o(load_stall)
  );

  typedef struct packed {
    logic [4:0] src;
    logic [4:0] mrd;
    logic       mwe;
    logic [4:0] wrd;
    logic       wwe;
    logic [1:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd3,  1'b1, 5'd0,  1'b0, 2'b01},
    '{5'd3,  5'd4,  1'b1, 5'd3,  1'b1, 2'b10},
    '{5'd1,  5'd1,  1'b1, 5'd1,  1'b1, 2'b01},
    '{5'd5,  5'd5,  1'b0, 5'd5,  1'b1, 2'b10},
    '{5'd5,  5'd5,  1'b0, 5'd5,  1'b0, 2'b00},
    '{5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00},
    '{5'd7,  5'd8,  1'b1, 5'd9,  1'b1, 2'b00},
    '{5'd31, 5'd31, 1'b1, 5'd2,  1'b0, 2'b01},
    '{5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 2'b10},
    '{5'd2,  5'd2,  1'b0, 5'd2,  1'b0, 2'b00}
  };

  localparam logic [DW-1:0] ALU_V = 32'hAAAA_0001;
  localparam logic [DW-1:0] WB_V  = 32'hBBBB_0002;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ex_src_idx = '0; id_src_idx = '0;
    ex_src_val[0] = 32'h1111_0000; ex_src_val[1] = 32'h2222_0000;
    rf_rdata[0] = 32'h3333_0000;   rf_rdata[1] = 32'h4444_0000;
    exm_rd = '0; mwb_rd = '0; ex_rd = '0;
    exm_we = 1'b0; mwb_we = 1'b0; ex_is_load = 1'b0;
    exm_alu = ALU_V; mwb_data = WB_V;
  endtask

  // drive at negedge, sample 1 ns later, clear of posedge
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  function automatic string sel_req(input logic [1:0] s);
    return (s == 2'b01) ? "R1" : (s == 2'b10) ? "R2" : "R4";
  endfunction

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R4 idle sel0", 64'(ex_sel[0]), 64'd0);
    chk("R4 idle sel1", 64'(ex_sel[1]), 64'd0);
    chk("R7 idle id0", 64'(id_opnd[0]), 64'h3333_0000);
    chk("R8 idle stall", 64'(load_stall), 64'd0);

    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < N; k++) begin
        @(negedge clk);
        idle();
        ex_src_idx[k]   = VECS[v].src;
        ex_src_idx[1-k] = 5'd6;
        exm_rd = VECS[v].mrd; exm_we = VECS[v].mwe;
        mwb_rd = VECS[v].wrd; mwb_we = VECS[v].wwe;
        #1;
        chk((v == 2) ? "R3 chain prio" : (v == 5) ? "R5 zero idx" : sel_req(VECS[v].exp),
            64'(ex_sel[k]), 64'(VECS[v].exp));
        chk(sel_req(VECS[v].exp), 64'(ex_opnd[k]),
            (VECS[v].exp == 2'b01) ? 64'(ALU_V) :
            (VECS[v].exp == 2'b10) ? 64'(WB_V) : 64'(ex_src_val[k]));
        chk("R6 other sel", 64'(ex_sel[1-k]), 64'd0);
        chk("R6 other data", 64'(ex_opnd[1-k]), 64'(ex_src_val[1-k]));
      end
    end

    // R6: both operands forwarded from different stages at once
    idle(); ex_src_idx[0] = 5'd4; ex_src_idx[1] = 5'd9;
    exm_rd = 5'd4; exm_we = 1'b1; mwb_rd = 5'd9; mwb_we = 1'b1;
    settle();
    chk("R6 op0 mem", 64'(ex_opnd[0]), 64'(ALU_V));
    chk("R6 op1 wb", 64'(ex_opnd[1]), 64'(WB_V));

    // R7 decode write-through
    idle(); id_src_idx[0] = 5'd12; id_src_idx[1] = 5'd13;
    mwb_rd = 5'd12; mwb_we = 1'b1;
    settle();
    chk("R7 byp hit", 64'(id_opnd[0]), 64'(WB_V));
    chk("R7 byp miss", 64'(id_opnd[1]), 64'h4444_0000);
    mwb_we = 1'b0;
    settle();
    chk("R7 we low", 64'(id_opnd[0]), 64'h3333_0000);
    id_src_idx[1] = 5'd0; mwb_rd = 5'd0; mwb_we = 1'b1;
    settle();
    chk("R7 zero idx", 64'(id_opnd[1]), 64'h4444_0000);

    // R8 load-use
    idle(); ex_is_load = 1'b1; ex_rd = 5'd8; id_src_idx[0] = 5'd8; id_src_idx[1] = 5'd3;
    settle();
    chk("R8 src0 hit", 64'(load_stall), 64'd1);
    id_src_idx[0] = 5'd2; id_src_idx[1] = 5'd8;
    settle();
    chk("R8 src1 hit", 64'(load_stall), 64'd1);
    ex_is_load = 1'b0;
    settle();
    chk("R8 not load", 64'(load_stall), 64'd0);
    ex_is_load = 1'b1; ex_rd = 5'd0; id_src_idx[1] = 5'd0;
    settle();
    chk("R8 rd zero", 64'(load_stall), 64'd0);
    ex_rd = 5'd17; id_src_idx[0] = 5'd16; id_src_idx[1] = 5'd18;
    settle();
    chk("R8 no match", 64'(load_stall), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule